// File: doc/BRIEF.md
# I2C Bus Timing Calculator

This block turns a functional clock frequency and a requested I2C bit rate into the counts that an I2C master needs to shape SCL and SDA. A one-cycle start pulse captures both inputs. The calculator then walks the clock prescaler upward from divide-by-1. For each setting it divides the clock by the scaled bit rate to get the cycles per bit. It splits that period so the low phase is about twice the high phase, and it stops at the first setting whose low count is small enough. The setup/hold count and the data-valid delay are derived from the high count. The bit rate is also sorted into one of five speed classes.

All divisions run on one shared multi-cycle restoring divider, so a full result takes a few hundred cycles in the worst case. The results appear on the outputs, and `done` pulses for one cycle in the same cycle. They then hold until the next calculation completes. The `err` flag is set when the calculation cannot produce usable counts.

Top module: `i2c_timing_calc`

## Requirements
- R1: After reset, `done` and `err` are 0, and every timing field, `prescale`, `speedMode` and `timingWord` are 0.
- R2: `speedMode` gives the class of the captured bit rate: 0 below 400000, 1 below 1000000, 2 below 3400000, 3 below 5000000, and 4 otherwise. It is reported on errors too.
- R3: Prescale values p = 0, 1, 2 … 7 are tried in ascending order, with cycles = floor(clock / (2^p · rate)). The first p whose low count is below 64 is reported in `prescale`.
- R4: For the chosen p, `sclHigh` = floor((cycles + 2) / 3) and `sclLow` = cycles − `sclHigh`.
- R5: `setHold` equals `sclHigh`, and `dataValid` equals floor(`sclHigh` / 2).
- R6: `timingWord` packs `dataValid` in [31:24], `setHold` in [23:16], `sclHigh` in [15:8] and `sclLow` in [7:0].
- R7: If no prescale value gives a low count below 64, `err` is 1 and `prescale`, `sclHigh`, `sclLow`, `setHold` and `dataValid` are 0.
- R8: A bit rate of 0 performs no division. It reports `err` = 1 with all timing fields 0, and `done` rises within 2 clock cycles of the start pulse being sampled.
- R9: `done` is high for exactly one cycle per calculation. Between completions all outputs hold their values, whatever the inputs do.
- R10: A start pulse that arrives while a calculation is running is ignored: the running calculation completes with its own result, and no second completion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request; captures `clkHz` and `bitRate` when idle |
| clkHz | input | 32 | Functional clock frequency in Hz |
| bitRate | input | 32 | Requested bit rate in bit/s |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Result unusable (zero rate or no prescale fits) |
| prescale | output | 3 | Chosen prescaler exponent |
| sclHigh | output | 8 | SCL high count |
| sclLow | output | 8 | SCL low count |
| setHold | output | 8 | Setup/hold count |
| dataValid | output | 8 | Data-valid delay count |
| speedMode | output | 3 | Speed class of the bit rate |
| timingWord | output | 32 | Packed timing fields |

## Verification
The assertions check, on every cycle, the properties that can be seen from the outputs alone. `done` never lasts two cycles. Every good result has a low count below 64 and a low:high ratio within the 2:1 rounding band. Error results carry zero counts. The speed class changes only when a completion is flagged. The exact quotients, the chosen prescaler and the speed class boundaries depend on the input values, so only the bench's scenarios show them. These scenarios include the largest and smallest prescaler cases, the 63/64 low-count boundary, a zero bit rate, its latency, and a start pulse during a running calculation.

// File: rtl/i2c_timing_pkg.sv
package i2c_timing_pkg;

  localparam int unsigned STD_LIMIT   = 400000;
  localparam int unsigned FAST_LIMIT  = 1000000;
  localparam int unsigned FPLUS_LIMIT = 3400000;
  localparam int unsigned HS_LIMIT    = 5000000;

  typedef enum logic [2:0] {
    SPD_STANDARD = 3'd0,
    SPD_FAST     = 3'd1,
    SPD_FASTPLUS = 3'd2,
    SPD_HIGH     = 3'd3,
    SPD_ULTRA    = 3'd4
  } speed_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic goCyc;
    logic goThird;
    logic takeCycles;
    logic takeHigh;
    logic nextPre;
    logic commitOk;
    logic commitErr;
  } calcStrobe_t;

endpackage

// File: rtl/i2c_timing_div.sv
module i2c_timing_div #(
  parameter int N = 33,
  parameter int D = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [N-1:0] dividend,
  input  logic [D-1:0] divisor,
  output logic         divDone,
  output logic [N-1:0] quotient
);
  localparam int CW = $clog2(N + 1);

  logic [D-1:0]  rem;
  logic [D-1:0]  dvsr;
  logic [N-1:0]  quo;
  logic [CW-1:0] cnt;
  logic          busy;
  logic [D:0]    remShift;
  logic          fitsSub;

  assign remShift = {rem, quo[N-1]};
  assign fitsSub  = remShift >= {1'b0, dvsr};
  assign quotient = quo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem     <= '0;
      dvsr    <= '0;
      quo     <= '0;
      cnt     <= '0;
      busy    <= 1'b0;
      divDone <= 1'b0;
    end else begin
      divDone <= 1'b0;
      if (go) begin
        rem  <= '0;
        dvsr <= divisor;
        quo  <= dividend;
        cnt  <= CW'(N);
        busy <= 1'b1;
      end else if (busy) begin
        if (fitsSub) begin
          rem <= D'(remShift - {1'b0, dvsr});
          quo <= {quo[N-2:0], 1'b1};
        end else begin
          rem <= remShift[D-1:0];
          quo <= {quo[N-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy    <= 1'b0;
          divDone <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_timing_ctrl.sv
module i2c_timing_ctrl
  import i2c_timing_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        divDone,
  input  logic        rateZero,
  input  logic        lowFits,
  input  logic        preLast,
  output calcStrobe_t stb
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_WCYC, ST_THIRD, ST_WTHIRD, ST_JUDGE
  } state_t;

  state_t state, stateNxt;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (start) begin
        stb.load = 1'b1;
        stateNxt = ST_CHECK;
      end
      ST_CHECK: if (rateZero) begin
        stb.commitErr = 1'b1;
        stateNxt      = ST_IDLE;
      end else begin
        stb.goCyc = 1'b1;
        stateNxt  = ST_WCYC;
      end
      ST_WCYC: if (divDone) begin
        stb.takeCycles = 1'b1;
        stateNxt       = ST_THIRD;
      end
      ST_THIRD: begin
        stb.goThird = 1'b1;
        stateNxt    = ST_WTHIRD;
      end
      ST_WTHIRD: if (divDone) begin
        stb.takeHigh = 1'b1;
        stateNxt     = ST_JUDGE;
      end
      ST_JUDGE: if (lowFits) begin
        stb.commitOk = 1'b1;
        stateNxt     = ST_IDLE;
      end else if (preLast) begin
        stb.commitErr = 1'b1;
        stateNxt      = ST_IDLE;
      end else begin
        stb.nextPre = 1'b1;
        stateNxt    = ST_CHECK;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNxt;
  end
endmodule

// File: rtl/i2c_timing_dp.sv
module i2c_timing_dp
  import i2c_timing_pkg::*;
#(
  parameter int CLK_W     = 32,
  parameter int RATE_W    = 32,
  parameter int PRE_STEPS = 8,
  parameter int FIELD_W   = 8,
  parameter int LOW_LIMIT = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  calcStrobe_t                stb,
  input  logic [CLK_W-1:0]           clkHz,
  input  logic [RATE_W-1:0]          bitRate,
  output logic                       divDone,
  output logic                       rateZero,
  output logic                       lowFits,
  output logic                       preLast,
  output logic                       doneQ,
  output logic                       errQ,
  output logic [$clog2(PRE_STEPS)-1:0] preQ,
  output logic [FIELD_W-1:0]         highQ,
  output logic [FIELD_W-1:0]         lowQ,
  output logic [FIELD_W-1:0]         holdQ,
  output logic [FIELD_W-1:0]         validQ,
  output speed_t                     modeQ
);
  localparam int PRE_W = $clog2(PRE_STEPS);
  localparam int DIVN  = CLK_W + 1;
  localparam int DIVD  = RATE_W + PRE_STEPS;

  logic [CLK_W-1:0]  clkReg;
  logic [RATE_W-1:0] rateReg;
  logic [PRE_W-1:0]  pre;
  logic [DIVN-1:0]   cyclesReg, highReg, lowVal, quotient, dividend;
  logic [DIVD-1:0]   divisor;
  speed_t            modeNow;

  assign dividend = stb.goThird ? cyclesReg + DIVN'(2) : DIVN'(clkReg);
  assign divisor  = stb.goThird ? DIVD'(3) : (DIVD'(rateReg) << pre);

  i2c_timing_div #(.N(DIVN), .D(DIVD)) u_div (
    .clk(clk), .rst_n(rst_n), .go(stb.goCyc | stb.goThird),
    .dividend(dividend), .divisor(divisor),
    .divDone(divDone), .quotient(quotient)
  );

  assign lowVal   = cyclesReg - highReg;
  assign lowFits  = lowVal < DIVN'(LOW_LIMIT);
  assign rateZero = rateReg == '0;
  assign preLast  = pre == PRE_W'(PRE_STEPS - 1);

  always_comb begin
    if (rateReg < RATE_W'(STD_LIMIT))        modeNow = SPD_STANDARD;
    else if (rateReg < RATE_W'(FAST_LIMIT))  modeNow = SPD_FAST;
    else if (rateReg < RATE_W'(FPLUS_LIMIT)) modeNow = SPD_FASTPLUS;
    else if (rateReg < RATE_W'(HS_LIMIT))    modeNow = SPD_HIGH;
    else                                     modeNow = SPD_ULTRA;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkReg <= '0; rateReg <= '0; pre <= '0;
      cyclesReg <= '0; highReg <= '0;
      doneQ <= 1'b0; errQ <= 1'b0; preQ <= '0;
      highQ <= '0; lowQ <= '0; holdQ <= '0; validQ <= '0;
      modeQ <= SPD_STANDARD;
    end else begin
      if (stb.load) begin
        clkReg  <= clkHz;
        rateReg <= bitRate;
        pre     <= '0;
      end
      if (stb.nextPre)    pre       <= pre + 1'b1;
      if (stb.takeCycles) cyclesReg <= quotient;
      if (stb.takeHigh)   highReg   <= quotient;
      doneQ <= stb.commitOk | stb.commitErr;
      if (stb.commitOk) begin
        errQ   <= 1'b0;
        preQ   <= pre;
        highQ  <= highReg[FIELD_W-1:0];
        lowQ   <= lowVal[FIELD_W-1:0];
        holdQ  <= highReg[FIELD_W-1:0];
        validQ <= highReg[FIELD_W:1];
        modeQ  <= modeNow;
      end else if (stb.commitErr) begin
        errQ  <= 1'b1;
        preQ  <= '0;
        highQ <= '0; lowQ <= '0; holdQ <= '0; validQ <= '0;
        modeQ <= modeNow;
      end
    end
  end
endmodule

// File: rtl/i2c_timing_calc.sv
module i2c_timing_calc
  import i2c_timing_pkg::*;
#(
  parameter int CLK_W     = 32,
  parameter int RATE_W    = 32,
  parameter int PRE_STEPS = 8,
  parameter int FIELD_W   = 8,
  parameter int LOW_LIMIT = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [CLK_W-1:0]             clkHz,
  input  logic [RATE_W-1:0]            bitRate,
  output logic                         done,
  output logic                         err,
  output logic [$clog2(PRE_STEPS)-1:0] prescale,
  output logic [FIELD_W-1:0]           sclHigh,
  output logic [FIELD_W-1:0]           sclLow,
  output logic [FIELD_W-1:0]           setHold,
  output logic [FIELD_W-1:0]           dataValid,
  output logic [2:0]                   speedMode,
  output logic [4*FIELD_W-1:0]         timingWord
);
  calcStrobe_t stb;
  logic        divDone, rateZero, lowFits, preLast;
  speed_t      modeQ;

  i2c_timing_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .divDone(divDone),
    .rateZero(rateZero), .lowFits(lowFits), .preLast(preLast), .stb(stb)
  );

  i2c_timing_dp #(
    .CLK_W(CLK_W), .RATE_W(RATE_W), .PRE_STEPS(PRE_STEPS),
    .FIELD_W(FIELD_W), .LOW_LIMIT(LOW_LIMIT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .clkHz(clkHz), .bitRate(bitRate),
    .divDone(divDone), .rateZero(rateZero), .lowFits(lowFits), .preLast(preLast),
    .doneQ(done), .errQ(err), .preQ(prescale), .highQ(sclHigh), .lowQ(sclLow),
    .holdQ(setHold), .validQ(dataValid), .modeQ(modeQ)
  );

  assign speedMode  = modeQ;
  assign timingWord = {dataValid, setHold, sclHigh, sclLow};
endmodule

// File: rtl/i2c_timing_calc_chk.sv
module i2c_timing_calc_chk #(
  parameter int FIELD_W   = 8,
  parameter int LOW_LIMIT = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               done,
  input logic               err,
  input logic [FIELD_W-1:0] sclHigh,
  input logic [FIELD_W-1:0] sclLow,
  input logic [2:0]         speedMode
);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_mode_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(speedMode));

  assert_mode_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    speedMode <= 3'd4);

  assert_low_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> ({2'b0, sclLow} < (FIELD_W + 2)'(LOW_LIMIT)));

  assert_ratio_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (({2'b0, sclLow} <= {1'b0, sclHigh, 1'b0}) &&
                        ({2'b0, sclLow} + 2 >= {1'b0, sclHigh, 1'b0})));

  assert_err_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (sclHigh == '0 && sclLow == '0));
endmodule

bind i2c_timing_calc i2c_timing_calc_chk #(.FIELD_W(FIELD_W), .LOW_LIMIT(LOW_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .err(err),
  .sclHigh(sclHigh), .sclLow(sclLow), .speedMode(speedMode)
);

// File: tb/i2c_timing_calc_bench.sv
`timescale 1ns/1ps
module i2c_timing_calc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] clkHz = '0, bitRate = '0;
  logic        done, err;
  logic [2:0]  prescale, speedMode;
  logic [7:0]  sclHigh, sclLow, setHold, dataValid;
  logic [31:0] timingWord;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;

  i2c_timing_calc u_i2c_timing_calc (
    .clk(clk), .rst_n(rst_n), .start(start), .clkHz(clkHz), .bitRate(bitRate),
    .done(done), .err(err), .prescale(prescale), .sclHigh(sclHigh),
    .sclLow(sclLow), .setHold(setHold), .dataValid(dataValid),
    .speedMode(speedMode), .timingWord(timingWord)
  );

  localparam int NV = 13;
  localparam int unsigned vClk [NV] = '{24000000, 24000000, 48000000, 60000000,
    100000000, 100000000, 95, 96, 12160, 12288, 32'hFFFF_FFFF, 1000, 50000000};
  localparam int unsigned vRate[NV] = '{100000, 400000, 1000000, 3400000,
    5000000, 399999, 1, 1, 1, 1, 1, 5000, 0};
  localparam int vErr [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 1};
  localparam int vPre [NV] = '{2, 0, 0, 0, 0, 2, 0, 1, 7, 0, 0, 0, 0};
  localparam int vHigh[NV] = '{20, 20, 16, 6, 7, 21, 32, 16, 32, 0, 0, 0, 0};
  localparam int vLow [NV] = '{40, 40, 32, 11, 13, 41, 63, 32, 63, 0, 0, 0, 0};
  localparam int vMode[NV] = '{0, 1, 2, 3, 4, 0, 0, 0, 0, 0, 0, 0, 0};

  task automatic check(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runCalc(input int unsigned c, input int unsigned r, output int lat);
    @(negedge clk);
    clkHz = c; bitRate = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 3000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic expectResult(input int i);
    check("R3/R7 err", err, vErr[i]);
    check("R3 prescale", prescale, vPre[i]);
    check("R4 sclHigh", sclHigh, vHigh[i]);
    check("R4 sclLow", sclLow, vLow[i]);
    check("R5 setHold", setHold, vHigh[i]);
    check("R5 dataValid", dataValid, vHigh[i] / 2);
    check("R6 timingWord", timingWord,
          ((vHigh[i] / 2) << 24) | (vHigh[i] << 16) | (vHigh[i] << 8) | vLow[i]);
    check("R2 speedMode", speedMode, vMode[i]);
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 done", done, 0);
    check("R1 err", err, 0);
    check("R1 timingWord", timingWord, 0);
    check("R1 prescale", prescale, 0);
    check("R1 speedMode", speedMode, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      runCalc(vClk[i], vRate[i], lat);
      check("R9 done seen", done, 1);
      expectResult(i);
      @(negedge clk);
      check("R9 done single cycle", done, 0);
      repeat (2) @(negedge clk);
    end

    // R8 zero rate latency
    runCalc(12345, 0, lat);
    check("R8 err", err, 1);
    check("R8 latency within 2", (lat <= 2) ? 1 : 0, 1);

    // R9 outputs hold while inputs change without start
    runCalc(vClk[0], vRate[0], lat);
    @(negedge clk);
    clkHz = 7; bitRate = 9000000;
    repeat (20) @(negedge clk);
    check("R9 no spurious done", done, 0);
    expectResult(0);

    // R10 start during a running calculation
    @(negedge clk);
    clkHz = vClk[5]; bitRate = vRate[5]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    clkHz = 50; bitRate = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 3000) begin
      @(negedge clk);
      lat++;
    end
    check("R10 first result kept err", err, 0);
    expectResult(5);
    begin
      int extra = 0;
      for (int k = 0; k < 400; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      check("R10 no second completion", extra, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule